// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block is the bus-side front end of a 16-bit processor that uses segmented memory. It fetches code ahead of the execution side. Each fetch reads one 16-bit word over the memory bus, and the code bytes wait in a six-entry byte queue. The execution side takes them one at a time through a valid/ready pop port. Physical addresses are 20 bits wide. Each one is formed from a 16-bit segment shifted left by four, plus a 16-bit offset. Code fetches use the current code segment and instruction pointer. Operand cycles use the segment and offset that the execution side supplies.

One memory request is in flight at any time. A prefetch is started only when the queue has at least two free bytes and no operand request is waiting. An operand request that arrives during a fetch waits for that fetch to finish, and then it goes ahead of any further prefetch. A flush carries a new code segment and instruction pointer. It empties the queue, discards the data of any fetch still in flight, and restarts fetching at the target. When the target offset is odd, the first fetch reads the aligned word and keeps only its upper byte.

Top module: `prefetch_queue_unit`

## Requirements
- R1: The queue holds at most six bytes. With the consumer stalled it fills to six bytes, and all six are delivered afterwards.
- R2: A prefetch starts only when at least two queue bytes are free and op_req_i is low. With the queue full (or five bytes after an odd start) and no operand request, mem_req_o stays low.
- R3: Fetch addresses are always even (bit 0 = 0). For an even offset, the low byte mem_rdata_i[7:0] is queued first and then the high byte mem_rdata_i[15:8], and the pointer advances by 2. For an odd offset, only mem_rdata_i[15:8] is queued and the pointer advances by 1.
- R4: Every physical address is ({seg, 4'b0000} + off) modulo 2^20. Code fetches use the code segment and instruction pointer. Operand cycles use op_seg_i and op_off_i.
- R5: Bytes leave in address order. A byte with q_valid_o high stays on q_data_o until q_ready_i accepts it, and q_valid_o is low while the queue is empty.
- R6: An operand request held on op_req_i while a fetch is in flight waits for that fetch's acknowledge. Its cycle is then the next memory request, with mem_we_o = op_we_i and, for writes, mem_wdata_o = op_wdata_i. op_done_o pulses in the acknowledge cycle with op_rdata_o = mem_rdata_i, and the queued bytes stay intact.
- R7: A flush leaves q_valid_o low in the following cycle, and fetching resumes at the flush target.
- R8: Data returned by a fetch that was in flight when a flush arrived is never queued.
- R9: Once raised, mem_req_o, mem_addr_o and mem_we_o hold steady until mem_ack_i.
- R10: During reset, q_valid_o, mem_req_o and op_done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Branch: clear the queue and load a new fetch point |
| flush_seg_i | input | 16 | New code segment |
| flush_off_i | input | 16 | New instruction pointer |
| q_data_o | output | 8 | Byte at the queue head |
| q_valid_o | output | 1 | Queue head is valid |
| q_ready_i | input | 1 | Consumer takes the head byte |
| op_req_i | input | 1 | Operand access request, held until op_done_o |
| op_we_i | input | 1 | Operand access is a write |
| op_seg_i | input | 16 | Operand segment |
| op_off_i | input | 16 | Operand offset |
| op_wdata_i | input | 16 | Operand write data |
| op_done_o | output | 1 | Operand cycle acknowledged |
| op_rdata_o | output | 16 | Operand read data, valid with op_done_o |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 20 | Physical address |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge, one-cycle pulse |
| mem_rdata_i | input | 16 | Read data, valid with mem_ack_i |

## Verification
A request is decided in one cycle, and mem_req_o rises at the next clock edge. Fetched bytes show on q_valid_o in the cycle after mem_ack_i. op_done_o and op_rdata_o are valid in the acknowledge cycle itself. A flush leaves the queue empty one edge later. The bench drives and samples only on falling edges. Pops wait on q_valid_o instead of counting a fixed latency, because that latency depends on the memory responder's delay, which the bench varies. Checks that depend on timing are tied to edges: the empty queue is checked at the first falling edge after a flush, and operand data is checked at the falling edge where op_done_o is high.

// File: rtl/pfq_pkg.sv
`timescale 1ns/1ps
package pfq_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_OPER  = 2'd2
  } bus_state_e;
endpackage

// File: rtl/pfq_addr_gen.sv
`timescale 1ns/1ps
module pfq_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int PA_W  = 20,
  parameter int SHIFT = 4
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PA_W-1:0]  addr_o
);
  localparam int SH_W = SEG_W + SHIFT;

  logic [SH_W-1:0] seg_sh;

  assign seg_sh = {seg_i, {SHIFT{1'b0}}};
  // carry out of the top bit wraps the address space
  assign addr_o = PA_W'(seg_sh) + PA_W'(off_i);
endmodule

// File: rtl/pfq_byte_fifo.sv
`timescale 1ns/1ps
module pfq_byte_fifo #(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic              push_two_i,
  input  logic [BYTE_W-1:0] b0_i,
  input  logic [BYTE_W-1:0] b1_i,
  input  logic              pop_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [BYTE_W-1:0] q_q   [DEPTH];
  logic [BYTE_W-1:0] mid_d [DEPTH];
  logic [BYTE_W-1:0] nxt_d [DEPTH];
  logic [LVL_W-1:0]  cnt_q, mid_cnt, nxt_cnt;

  // shift toward the head on pop, then append behind the survivors
  always_comb begin
    mid_cnt = cnt_q;
    for (int i = 0; i < DEPTH; i++) mid_d[i] = q_q[i];
    if (pop_i && cnt_q != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) mid_d[i] = q_q[i+1];
      mid_cnt = cnt_q - LVL_W'(1);
    end
    nxt_cnt = mid_cnt;
    for (int i = 0; i < DEPTH; i++) nxt_d[i] = mid_d[i];
    if (push_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (LVL_W'(i) == mid_cnt) nxt_d[i] = b0_i;
        if (push_two_i && LVL_W'(i) == mid_cnt + LVL_W'(1)) nxt_d[i] = b1_i;
      end
      nxt_cnt = mid_cnt + (push_two_i ? LVL_W'(2) : LVL_W'(1));
    end
    if (clr_i) nxt_cnt = '0;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q[g] <= '0;
      else         q_q[g] <= nxt_d[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_cnt;
  end

  assign data_o  = q_q[0];
  assign valid_o = (cnt_q != '0);
  assign level_o = cnt_q;
endmodule

// File: rtl/pfq_bus_arb.sv
`timescale 1ns/1ps
module pfq_bus_arb
  import pfq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       op_req_i,
  input  logic       room_i,
  input  logic       flush_i,
  input  logic       mem_ack_i,
  output bus_state_e state_o,
  output logic       fetch_go_o,
  output logic       oper_go_o,
  output logic       fetch_done_o,
  output logic       oper_done_o
);
  bus_state_e state_q, state_d;
  logic       drop_q;

  assign oper_go_o  = (state_q == BUS_IDLE) && op_req_i;
  assign fetch_go_o = (state_q == BUS_IDLE) && !op_req_i && room_i && !flush_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BUS_IDLE: begin
        if (oper_go_o)       state_d = BUS_OPER;
        else if (fetch_go_o) state_d = BUS_FETCH;
      end
      BUS_FETCH, BUS_OPER: if (mem_ack_i) state_d = BUS_IDLE;
      default: state_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUS_IDLE;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == BUS_FETCH && mem_ack_i)          drop_q <= 1'b0;
      else if (state_q == BUS_FETCH && flush_i)       drop_q <= 1'b1;
    end
  end

  // a flush in the return cycle also drops the word
  assign fetch_done_o = (state_q == BUS_FETCH) && mem_ack_i && !drop_q && !flush_i;
  assign oper_done_o  = (state_q == BUS_OPER) && mem_ack_i;
  assign state_o      = state_q;
endmodule

// File: rtl/prefetch_queue_unit.sv
`timescale 1ns/1ps
module prefetch_queue_unit
  import pfq_pkg::*;
#(
  parameter int Q_DEPTH = 6,
  parameter int SEG_W   = 16,
  parameter int OFF_W   = 16,
  parameter int PA_W    = 20,
  parameter int WORD_W  = 16,
  parameter logic [SEG_W-1:0] RESET_SEG = '0,
  parameter logic [OFF_W-1:0] RESET_OFF = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic [SEG_W-1:0]    flush_seg_i,
  input  logic [OFF_W-1:0]    flush_off_i,
  output logic [WORD_W/2-1:0] q_data_o,
  output logic                q_valid_o,
  input  logic                q_ready_i,
  input  logic                op_req_i,
  input  logic                op_we_i,
  input  logic [SEG_W-1:0]    op_seg_i,
  input  logic [OFF_W-1:0]    op_off_i,
  input  logic [WORD_W-1:0]   op_wdata_i,
  output logic                op_done_o,
  output logic [WORD_W-1:0]   op_rdata_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [PA_W-1:0]     mem_addr_o,
  output logic [WORD_W-1:0]   mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [WORD_W-1:0]   mem_rdata_i
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int LVL_W  = $clog2(Q_DEPTH + 1);

  bus_state_e        state;
  logic              fetch_go, oper_go, fetch_done, oper_done;
  logic [SEG_W-1:0]  cs_q;
  logic [OFF_W-1:0]  ip_q;
  logic [PA_W-1:0]   fetch_pa, oper_pa;
  logic [PA_W-1:0]   addr_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q;
  logic [LVL_W-1:0]  fill_lvl;
  logic              room, pop, odd;
  logic [BYTE_W-1:0] lo_byte, hi_byte;

  assign room    = fill_lvl <= LVL_W'(Q_DEPTH - 2);
  assign odd     = ip_q[0];
  assign lo_byte = mem_rdata_i[BYTE_W-1:0];
  assign hi_byte = mem_rdata_i[WORD_W-1:BYTE_W];
  assign pop     = q_valid_o && q_ready_i && !flush_i;

  pfq_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_fetch_ag (
    .seg_i  (cs_q),
    .off_i  (ip_q),
    .addr_o (fetch_pa)
  );

  pfq_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_oper_ag (
    .seg_i  (op_seg_i),
    .off_i  (op_off_i),
    .addr_o (oper_pa)
  );

  pfq_bus_arb i_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_req_i     (op_req_i),
    .room_i       (room),
    .flush_i      (flush_i),
    .mem_ack_i    (mem_ack_i),
    .state_o      (state),
    .fetch_go_o   (fetch_go),
    .oper_go_o    (oper_go),
    .fetch_done_o (fetch_done),
    .oper_done_o  (oper_done)
  );

  pfq_byte_fifo #(.DEPTH(Q_DEPTH), .BYTE_W(BYTE_W)) i_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (flush_i),
    .push_i     (fetch_done),
    .push_two_i (!odd),
    .b0_i       (odd ? hi_byte : lo_byte),
    .b1_i       (hi_byte),
    .pop_i      (pop),
    .data_o     (q_data_o),
    .valid_o    (q_valid_o),
    .level_o    (fill_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= RESET_SEG;
      ip_q <= RESET_OFF;
    end else if (flush_i) begin
      cs_q <= flush_seg_i;
      ip_q <= flush_off_i;
    end else if (fetch_done) begin
      ip_q <= ip_q + (odd ? OFF_W'(1) : OFF_W'(2));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (oper_go) begin
      addr_q  <= oper_pa;
      we_q    <= op_we_i;
      wdata_q <= op_wdata_i;
    end else if (fetch_go) begin
      addr_q  <= fetch_pa & ~PA_W'(1);
      we_q    <= 1'b0;
      wdata_q <= '0;
    end
  end

  assign mem_req_o   = (state != BUS_IDLE);
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign op_done_o   = oper_done;
  assign op_rdata_o  = oper_done ? mem_rdata_i : '0;
endmodule

// File: rtl/pfq_checker.sv
`timescale 1ns/1ps
module pfq_checker #(
  parameter int DEPTH  = 6,
  parameter int BYTE_W = 8,
  parameter int PA_W   = 20,
  parameter int LVL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              q_valid_o,
  input logic              q_ready_i,
  input logic [BYTE_W-1:0] q_data_o,
  input logic              op_req_i,
  input logic              op_done_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [PA_W-1:0]   mem_addr_o,
  input logic              mem_ack_i,
  input logic [LVL_W-1:0]  fill_lvl,
  input logic              fetch_go
);
  a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_lvl <= LVL_W'(DEPTH));

  a_r2_fetch_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_go |-> (fill_lvl <= LVL_W'(DEPTH - 2)) && !op_req_i);

  a_r5_hold_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o && !q_ready_i && !flush_i |=> q_valid_o && $stable(q_data_o));

  a_r6_done_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_o |-> mem_ack_i && mem_req_o);

  a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !q_valid_o);

  a_r9_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
endmodule

bind prefetch_queue_unit pfq_checker #(
  .DEPTH (Q_DEPTH),
  .BYTE_W(WORD_W / 2),
  .PA_W  (PA_W),
  .LVL_W ($clog2(Q_DEPTH + 1))
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .flush_i   (flush_i),
  .q_valid_o (q_valid_o),
  .q_ready_i (q_ready_i),
  .q_data_o  (q_data_o),
  .op_req_i  (op_req_i),
  .op_done_o (op_done_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .mem_addr_o(mem_addr_o),
  .mem_ack_i (mem_ack_i),
  .fill_lvl  (fill_lvl),
  .fetch_go  (fetch_go)
);

// File: tb/test_prefetch_queue_unit.sv
`timescale 1ns/1ps
module test_prefetch_queue_unit;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        flush_i;
  logic [15:0] flush_seg_i, flush_off_i;
  logic [7:0]  q_data_o;
  logic        q_valid_o, q_ready_i;
  logic        op_req_i, op_we_i;
  logic [15:0] op_seg_i, op_off_i, op_wdata_i;
  logic        op_done_o;
  logic [15:0] op_rdata_o;
  logic        mem_req_o, mem_we_o;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_ack_i;
  logic [15:0] mem_rdata_i;

  int n_tests = 0;
  int n_fail  = 0;
  int mem_lat = 2;
  int lat_cnt = 0;
  int misalign = 0;
  int unstable = 0;
  bit finished = 0;
  logic [19:0] last_waddr;
  logic [15:0] last_wdata;

  always #10 clk = ~clk;

  prefetch_queue_unit i_prefetch_queue_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .flush_i(flush_i), .flush_seg_i(flush_seg_i), .flush_off_i(flush_off_i),
    .q_data_o(q_data_o), .q_valid_o(q_valid_o), .q_ready_i(q_ready_i),
    .op_req_i(op_req_i), .op_we_i(op_we_i), .op_seg_i(op_seg_i), .op_off_i(op_off_i),
    .op_wdata_i(op_wdata_i), .op_done_o(op_done_o), .op_rdata_o(op_rdata_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] mword(input logic [19:0] a);
    return {mbyte(a | 20'h1), mbyte(a & ~20'h1)};
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  // memory responder: ack after mem_lat edges
  initial begin
    mem_ack_i   = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(posedge clk);
      if (mem_ack_i) begin
        mem_ack_i <= 1'b0;
        lat_cnt   <= 0;
      end else if (mem_req_o) begin
        if (lat_cnt >= mem_lat - 1) begin
          mem_ack_i   <= 1'b1;
          mem_rdata_i <= mword(mem_addr_o);
          if (mem_we_o) begin
            last_waddr <= mem_addr_o;
            last_wdata <= mem_wdata_o;
          end
        end else begin
          lat_cnt <= lat_cnt + 1;
        end
      end
    end
  end

  // bus monitor for R3 alignment and R9 stability
  initial begin
    logic        p_req, p_ack;
    logic [19:0] p_addr;
    p_req = 0; p_ack = 0; p_addr = '0;
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        if (mem_req_o && !p_req && !mem_we_o && mem_addr_o < 20'h80000 && mem_addr_o[0])
          misalign++;
        if (p_req && !p_ack && (!mem_req_o || mem_addr_o != p_addr)) unstable++;
      end
      p_req = mem_req_o; p_ack = mem_ack_i; p_addr = mem_addr_o;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pop_chk(input logic [7:0] exp, input string tag);
    int w = 0;
    while (!q_valid_o && w < 300) begin @(negedge clk); w++; end
    chk(q_valid_o && q_data_o == exp, tag, {23'b0, q_valid_o, q_data_o}, {24'h000001, exp});
    q_ready_i = 1'b1;
    @(negedge clk);
    q_ready_i = 1'b0;
  endtask

  task automatic flush_to(input logic [15:0] s, input logic [15:0] o);
    flush_i = 1'b1; flush_seg_i = s; flush_off_i = o;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    int w = 0;
    seen = 0;
    while (!op_done_o && w < 300) begin @(negedge clk); w++; end
    seen = op_done_o;
  endtask

  // {segment, offset, byte count}
  localparam logic [39:0] VECS [6] = '{
    {16'h1000, 16'h0000, 8'd6},
    {16'h1234, 16'h0005, 8'd9},
    {16'h0ABC, 16'h1FFF, 8'd4},
    {16'hFFFF, 16'h0020, 8'd8},
    {16'h0200, 16'h7FFE, 8'd12},
    {16'h0001, 16'h0003, 8'd3}
  };

  initial begin
    int          busy;
    bit          seen;
    logic [19:0] fa;
    bit          fa_acked;
    int          bad_order;
    rst_ni = 0; flush_i = 0; flush_seg_i = '0; flush_off_i = '0;
    q_ready_i = 0; op_req_i = 0; op_we_i = 0; op_seg_i = '0; op_off_i = '0; op_wdata_i = '0;
    repeat (3) @(negedge clk);
    chk(!q_valid_o, "R10 valid low in reset", {31'b0, q_valid_o}, 0);
    chk(!mem_req_o, "R10 req low in reset", {31'b0, mem_req_o}, 0);
    chk(!op_done_o, "R10 done low in reset", {31'b0, op_done_o}, 0);
    rst_ni = 1;
    @(negedge clk);

    // table walk: R4 address forming, R5 order, R3 odd starts
    for (int v = 0; v < 6; v++) begin
      logic [15:0] s, o;
      int n;
      s = VECS[v][39:24]; o = VECS[v][23:8]; n = int'(VECS[v][7:0]);
      mem_lat = 1 + v % 3;
      flush_to(s, o);
      chk(!q_valid_o, "R7 empty after flush", {31'b0, q_valid_o}, 0);
      for (int k = 0; k < n; k++)
        pop_chk(mbyte(phys(s, o + 16'(k))), "R4 R5 vector byte");
    end

    // R1 / R2: full queue idles the bus
    mem_lat = 2;
    flush_to(16'h1000, 16'h0000);
    repeat (40) @(negedge clk);
    busy = 0;
    repeat (20) begin if (mem_req_o) busy++; @(negedge clk); end
    chk(busy == 0, "R2 bus idle when full", busy, 0);
    for (int k = 0; k < 6; k++)
      pop_chk(mbyte(phys(16'h1000, 16'(k))), "R1 six bytes held");

    // R3: odd start stops at five bytes
    flush_to(16'h1000, 16'h0001);
    repeat (40) @(negedge clk);
    busy = 0;
    repeat (20) begin if (mem_req_o) busy++; @(negedge clk); end
    chk(busy == 0, "R2 R3 idle after odd fill", busy, 0);
    for (int k = 0; k < 5; k++)
      pop_chk(mbyte(phys(16'h1000, 16'(1 + k))), "R3 odd start bytes");

    // R6: operand read during fetch
    mem_lat = 3;
    flush_to(16'h1000, 16'h0010);
    while (!(mem_req_o && !mem_ack_i)) @(negedge clk);
    fa = mem_addr_o;
    fa_acked = 0; bad_order = 0;
    op_req_i = 1; op_we_i = 0; op_seg_i = 16'h8000; op_off_i = 16'h0124;
    begin
      int w = 0;
      while (!op_done_o && w < 300) begin
        if (mem_req_o && mem_addr_o != 20'h80124) begin
          if (mem_addr_o != fa) bad_order++;
          if (mem_ack_i) fa_acked = 1;
        end
        @(negedge clk); w++;
      end
    end
    chk(op_done_o && op_rdata_o == mword(20'h80124), "R6 read data",
        {15'b0, op_done_o, op_rdata_o}, {16'h0001, mword(20'h80124)});
    chk(fa_acked && bad_order == 0, "R6 fetch finishes first", {bad_order[30:0], fa_acked}, 1);
    op_req_i = 0;
    @(negedge clk);

    // R6: operand write
    op_req_i = 1; op_we_i = 1; op_off_i = 16'h0200; op_wdata_i = 16'hBEEF;
    wait_done(seen);
    chk(seen && mem_we_o && mem_addr_o == 20'h80200 && mem_wdata_o == 16'hBEEF, "R6 write cycle",
        {mem_addr_o[11:0], mem_wdata_o, 3'b0, mem_we_o}, {12'h200, 16'hBEEF, 4'h1});
    op_req_i = 0; op_we_i = 0;
    @(negedge clk);
    chk(last_waddr == 20'h80200 && last_wdata == 16'hBEEF, "R6 write landed",
        {last_waddr[15:0], last_wdata}, {16'h0200, 16'hBEEF});
    for (int k = 0; k < 4; k++)
      pop_chk(mbyte(phys(16'h1000, 16'(16 + k))), "R6 queue intact");

    // R8: flush while a fetch is in flight
    mem_lat = 3;
    flush_to(16'h2000, 16'h0000);
    while (!(mem_req_o && !mem_ack_i)) @(negedge clk);
    flush_to(16'h3000, 16'h0002);
    chk(!q_valid_o, "R7 empty after mid-fetch flush", {31'b0, q_valid_o}, 0);
    for (int k = 0; k < 6; k++)
      pop_chk(mbyte(phys(16'h3000, 16'(2 + k))), "R8 stale word dropped");

    chk(misalign == 0, "R3 aligned fetch addresses", misalign, 0);
    chk(unstable == 0, "R9 request held until ack", unstable, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule